// File: doc/BRIEF.md
# SCL Bit-Rate Divider

This block derives the serial-clock timing of an I2C master from the system clock. Two counting stages are cascaded. The first is a power-of-two prescaler whose ratio is picked by a 2-bit select. The second counts prescaler pulses up to a programmable half-period. That half-period is built from an 8-bit divider value, a fixed offset of three and an extra two when the digital-filter bit is set. Each time the second stage wraps, the block emits a one-cycle `tick_o` pulse and flips `scl_o`, so the serial clock runs at a 50% duty cycle.

Software writes a 4-bit mode word and an 8-bit divider word. The mode word carries the enable, the prescaler select and the filter bit. Changes to the select, the filter or the divider value are captured only when the second stage wraps, or while the block is stopped. A running serial clock therefore never produces a truncated or stretched phase.

Top module: `scl_rate_gen`

## Requirements
- R1: A synchronous reset (`rst` high) drives `tick_o` and `scl_o` to 0 and clears both counters.
- R2: While the enable bit is 0, `tick_o` stays 0 and `scl_o` is 0 from the following cycle on, and both counters are held at zero.
- R3: The prescaler divides by 32, 16, 8 or 4 for select values 0, 1, 2 and 3 (ratio 2^(5-select)).
- R4: With the filter bit clear, consecutive `tick_o` pulses are P*(D+3) clock cycles apart, where P is the prescaler ratio and D the divider value (0 to 255).
- R5: `scl_o` flips in exactly the cycle in which `tick_o` is 1 and holds its value in every other enabled cycle.
- R6: `tick_o` is never high for two cycles in a row.
- R7: A new select, filter or divider value written while running changes nothing in the period that is in progress. The period after the next `tick_o` uses the new value.
- R8: With the filter bit set, the tick spacing becomes P*(D+5) cycles.
- R9: The mode word places the enable in bit 0, the prescaler select in bits 2:1 and the filter in bit 3. The first `tick_o` after enabling appears P*(D+3+2F) cycles after the first enabled clock edge.
- R10: A full `scl_o` period is 2*P*(D+3+2F) clock cycles, giving a bit rate of clk / (P * 2 * (D+3+2F)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_reg | input | 4 | Enable (bit 0), prescaler select (bits 2:1), filter (bit 3) |
| div_reg | input | 8 | Second-stage divider value |
| tick_o | output | 1 | One-cycle pulse at every half SCL period |
| scl_o | output | 1 | SCL phase, toggles on each tick |

## Verification
Each of the four select values is run at a fixed divider value. Because these periods differ by exact powers of two, a prescaler select that is decoded wrongly shows up as a period error. Several divider values are then run at one select, including 0 and 255. This separates the fixed offset from the programmed value and exercises the full width of the second counter. Runs with the filter bit set and with the filter bit clear, at otherwise equal settings, isolate the filter term. A mid-period change of the divider and select must leave the running interval at its old length and apply only to the interval after it. Disabling while `scl_o` is high must return the line to 0 at once.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

   // bit positions inside the mode word (enable first, select above it)
   localparam int MODE_EN_BIT  = 0;
   localparam int MODE_SEL_LSB = 1;

   // fixed terms of the second-stage half period
   localparam int HALF_OFFSET = 3;
   localparam int FILT_EXTRA  = 2;

   typedef enum logic [1:0] {
      PRE_DIV32 = 2'd0,
      PRE_DIV16 = 2'd1,
      PRE_DIV8  = 2'd2,
      PRE_DIV4  = 2'd3
   } prediv_sel_e;

   // half-period in prescaler pulses for a given setting
   function automatic int half_ratio(input int div_val, input bit filt,
                                     input int offset, input int fextra);
      return div_val + offset + (filt ? fextra : 0);
   endfunction

endpackage

// File: rtl/scl_div_shadow.sv
module scl_div_shadow #(
   parameter int SEL_W      = 2,
   parameter int DIV_W      = 8,
   parameter int HALF_W     = 9,
   parameter int OFFSET     = 3,
   parameter int FEXTRA     = 2,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              term,
   input  logic [SEL_W-1:0]  sel_in,
   input  logic              filt_in,
   input  logic [DIV_W-1:0]  div_in,
   output logic [SEL_W-1:0]  sel_eff,
   output logic [HALF_W-1:0] half_eff
);

   localparam logic [HALF_W-1:0] OFS_V = HALF_W'(OFFSET);
   localparam logic [HALF_W-1:0] FEX_V = HALF_W'(FEXTRA);

   logic [HALF_W-1:0] half_in;
   logic [HALF_W-1:0] half_q;
   logic [SEL_W-1:0]  sel_q;
   logic              run_q;
   logic              load;

   generate
      if (HAS_FILTER) begin : g_filt
         assign half_in = HALF_W'(div_in) + OFS_V + (filt_in ? FEX_V : '0);
      end else begin : g_nofilt
         logic unused_filt;
         assign unused_filt = filt_in;
         assign half_in = HALF_W'(div_in) + OFS_V;
      end
   endgenerate

   // idle or wrapping: capture the register values
   assign load = !run_q || term;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= 1'b0;
         sel_q  <= '0;
         half_q <= OFS_V;
      end else begin
         run_q <= en;
         if (load) begin
            sel_q  <= sel_in;
            half_q <= half_in;
         end
      end
   end

   // first enabled edge uses the live values, later edges the captured ones
   assign sel_eff  = run_q ? sel_q  : sel_in;
   assign half_eff = run_q ? half_q : half_in;

   a_r7_hold_between_wraps: assert property (@(posedge clk) disable iff (rst)
      (run_q && en && !term) |=> (half_eff == $past(half_eff) && sel_eff == $past(sel_eff)))
      else $error("R7: settings changed inside a period");

endmodule

// File: rtl/scl_div_prescaler.sv
module scl_div_prescaler #(
   parameter int SEL_W    = 2,
   parameter int PRE_LOG2 = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             pre_tick
);

   localparam int PCW = (PRE_LOG2 > 0) ? PRE_LOG2 : 1;
   localparam logic [PCW-1:0] ALL1 = {PCW{1'b1}};

   generate
      if (PRE_LOG2 == 0) begin : g_bypass
         logic [SEL_W-1:0] unused_sel;
         logic             unused_clk;
         assign unused_sel = sel;
         assign unused_clk = clk ^ rst;
         assign pre_tick   = en;
      end else begin : g_count
         logic [PCW-1:0] cnt_q;
         logic [PCW-1:0] limit;

         // ratio 2^(PRE_LOG2 - sel): terminal value is all-ones shifted down
         assign limit    = ALL1 >> sel;
         assign pre_tick = en && (cnt_q == limit);

         always_ff @(posedge clk) begin
            if (rst || !en)      cnt_q <= '0;
            else if (pre_tick)   cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
         end

         a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= limit)
            else $error("R3: prescaler count beyond terminal value");

         a_r3_pulse_spacing: assert property (@(posedge clk) disable iff (rst)
            pre_tick |=> !pre_tick)
            else $error("R3: prescaler pulses back to back");

         a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
            !en |=> cnt_q == '0)
            else $error("R2: prescaler not held at zero");
      end
   endgenerate

endmodule

// File: rtl/scl_div_halfcnt.sv
module scl_div_halfcnt #(
   parameter int HALF_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              step,
   input  logic [HALF_W-1:0] half,
   output logic              term
);

   localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

   logic [HALF_W-1:0] cnt_q;
   logic [HALF_W-1:0] last;

   assign last = half - ONE;
   assign term = en && step && (cnt_q == last);

   always_ff @(posedge clk) begin
      if (rst || !en)  cnt_q <= '0;
      else if (term)   cnt_q <= '0;
      else if (step)   cnt_q <= cnt_q + ONE;
   end

   a_r4_count_below_half: assert property (@(posedge clk) disable iff (rst)
      cnt_q < half)
      else $error("R4: half counter reached its ratio");

   a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
      !en |=> cnt_q == '0)
      else $error("R2: half counter not held at zero");

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
   parameter int SEL_W      = 2,
   parameter int DIV_W      = 8,
   parameter int PRE_LOG2   = 5,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [SEL_W+1:0]      mode_reg,
   input  logic [DIV_W-1:0]      div_reg,
   output logic                  tick_o,
   output logic                  scl_o
);
   import scl_div_pkg::*;

   localparam int FILT_BIT = MODE_SEL_LSB + SEL_W;
   localparam int MAX_HALF = (1 << DIV_W) - 1 + HALF_OFFSET + FILT_EXTRA;
   localparam int HALF_W   = $clog2(MAX_HALF + 1);

   generate
      if (PRE_LOG2 < (1 << SEL_W) - 1) begin : g_bad_pre
         $error("PRE_LOG2 too small for the select range");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic             en;
   logic [SEL_W-1:0] sel_raw;
   logic             filt_raw;
   logic [SEL_W-1:0] sel_eff;
   logic [HALF_W-1:0] half_eff;
   logic             pre_tick;
   logic             term;
   logic             tick_q;
   logic             scl_q;

   assign en       = mode_reg[MODE_EN_BIT];
   assign sel_raw  = mode_reg[MODE_SEL_LSB +: SEL_W];
   assign filt_raw = mode_reg[FILT_BIT];

   scl_div_shadow #(
      .SEL_W(SEL_W), .DIV_W(DIV_W), .HALF_W(HALF_W),
      .OFFSET(HALF_OFFSET), .FEXTRA(FILT_EXTRA), .HAS_FILTER(HAS_FILTER)
   ) u_shadow (
      .clk(clk), .rst(rst), .en(en), .term(term),
      .sel_in(sel_raw), .filt_in(filt_raw), .div_in(div_reg),
      .sel_eff(sel_eff), .half_eff(half_eff)
   );

   scl_div_prescaler #(.SEL_W(SEL_W), .PRE_LOG2(PRE_LOG2)) u_pre (
      .clk(clk), .rst(rst), .en(en), .sel(sel_eff), .pre_tick(pre_tick)
   );

   scl_div_halfcnt #(.HALF_W(HALF_W)) u_half (
      .clk(clk), .rst(rst), .en(en), .step(pre_tick), .half(half_eff), .term(term)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         tick_q <= 1'b0;
         scl_q  <= 1'b0;
      end else if (!en) begin
         tick_q <= 1'b0;
         scl_q  <= 1'b0;
      end else begin
         tick_q <= term;
         if (term) scl_q <= ~scl_q;
      end
   end

   assign tick_o = tick_q;
   assign scl_o  = scl_q;

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !en |=> (!tick_o && !scl_o))
      else $error("R2: output active while disabled");

   a_r5_toggle_on_tick: assert property (@(posedge clk) disable iff (rst)
      tick_o |-> (scl_o != $past(scl_o)))
      else $error("R5: tick without SCL toggle");

   a_r5_steady_between: assert property (@(posedge clk) disable iff (rst)
      ($past(en) && !tick_o) |-> (scl_o == $past(scl_o)))
      else $error("R5: SCL moved without tick");

   a_r6_single_cycle_tick: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o)
      else $error("R6: tick wider than one cycle");

   a_r1_reset_clears: assert property (@(posedge clk)
      $past(rst) |-> (!tick_o && !scl_o))
      else $error("R1: outputs not cleared by reset");

endmodule

// File: tb/scl_rate_gen_bench.sv
module scl_rate_gen_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] mode_reg = 4'h0;
   logic [7:0] div_reg = 8'h0;
   logic       tick_o;
   logic       scl_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   scl_rate_gen u_scl_rate_gen (
      .clk(clk), .rst(rst), .mode_reg(mode_reg), .div_reg(div_reg),
      .tick_o(tick_o), .scl_o(scl_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_n(input int sel, input int dv, input int f);
      return (32 >> sel) * (dv + 3 + 2 * f);
   endfunction

   task automatic set_mode(input bit en, input int sel, input bit f);
      mode_reg = {f, 2'(sel), en};
   endtask

   // counts negedges until tick_o is seen high
   task automatic wait_tick(output int n, input int limit);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tick_o && n < limit);
   endtask

   task automatic stop_run();
      @(negedge clk);
      set_mode(1'b0, 0, 1'b0);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 tick after reset", int'(tick_o), 0);
      chk("R1 scl after reset", int'(scl_o), 0);
   endtask

   task automatic t_idle();
      int seen = 0;
      div_reg = 8'd0;
      set_mode(1'b0, 3, 1'b0);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (tick_o || scl_o) seen++;
      end
      chk("R2 no activity while disabled", seen, 0);
   endtask

   task automatic run_and_measure(input string req, input int sel, input int dv, input bit f);
      int n;
      stop_run();
      div_reg = 8'(dv);
      set_mode(1'b1, sel, f);
      wait_tick(n, 20000);
      chk({req, " first tick latency (R9)"}, n, exp_n(sel, dv, f));
      wait_tick(n, 20000);
      chk({req, " tick period"}, n, exp_n(sel, dv, f));
   endtask

   task automatic t_prediv();
      for (int s = 0; s < 4; s++) run_and_measure("R3 prescaler", s, 2, 1'b0);
   endtask

   task automatic t_divider();
      run_and_measure("R4 div0", 3, 0, 1'b0);
      run_and_measure("R4 div1", 3, 1, 1'b0);
      run_and_measure("R4 div100", 3, 100, 1'b0);
      run_and_measure("R4 div255", 3, 255, 1'b0);
   endtask

   task automatic t_filter();
      run_and_measure("R8 filter", 2, 7, 1'b1);
      run_and_measure("R8 filter max", 0, 255, 1'b1);
   endtask

   task automatic t_scl();
      int n;
      int hold;
      logic s;
      stop_run();
      div_reg = 8'd0;
      set_mode(1'b1, 3, 1'b0);
      wait_tick(n, 1000);
      s = scl_o;
      chk("R5 scl high at first tick", int'(s), 1);
      @(negedge clk);
      chk("R6 tick drops after one cycle", int'(tick_o), 0);
      hold = 1;
      while (!tick_o && hold < 1000) begin
         if (scl_o != s) break;
         @(negedge clk);
         hold++;
      end
      chk("R5 scl holds until next tick", hold, 12);
      chk("R5 scl toggles on tick", int'(scl_o), int'(!s));
      // full period rising to rising
      wait_tick(n, 1000);
      chk("R10 scl back high after two ticks", int'(scl_o), 1);
      chk("R10 second half length", n, 12);
   endtask

   task automatic t_update();
      int n;
      stop_run();
      div_reg = 8'd10;
      set_mode(1'b1, 3, 1'b0);
      wait_tick(n, 5000);
      repeat (5) @(negedge clk);
      div_reg = 8'd20;
      set_mode(1'b1, 2, 1'b0);
      wait_tick(n, 5000);
      chk("R7 running period unchanged", n + 5, exp_n(3, 10, 0));
      wait_tick(n, 5000);
      chk("R7 new setting after wrap", n, exp_n(2, 20, 0));
   endtask

   task automatic t_stop();
      int n;
      stop_run();
      div_reg = 8'd0;
      set_mode(1'b1, 3, 1'b0);
      wait_tick(n, 1000);
      chk("R2 scl high before stop", int'(scl_o), 1);
      set_mode(1'b0, 3, 1'b0);
      @(negedge clk);
      chk("R2 scl cleared on disable", int'(scl_o), 0);
      chk("R2 tick low on disable", int'(tick_o), 0);
   endtask

   initial begin
      #(8 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_idle();
      t_prediv();
      t_divider();
      t_filter();
      t_scl();
      t_update();
      t_stop();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule